// File: doc/BRIEF.md
# Four-Port GPIO Bank with Indirect Pin Setup

This block is a general-purpose I/O controller for 29 pads. The pads are grouped into byte-wide ports: three full ports of eight pins and a fourth port of five pins. A byte-wide runtime bus reaches the data registers. The first two ports also carry edge-event logic that drives one level interrupt.

The drive setup of each pin is reached through a second, indirect interface. Software first writes a pin-select byte that names a port and a bit. It then reads or writes a small setup byte for that pin. The setup byte holds the output enable, the drive style (open-drain or push-pull) and the pull-up request.

Pad inputs pass through a two-flop synchronizer before any register or event logic sees them. All outputs are registered.

Reads on both interfaces are registered. Present an address in one cycle, and the data appears after the next rising clock edge.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, every data-out, event-enable, event-status, pin-select and pin-setup bit is 0. All pad_oe, pad_out and pad_pu bits are 0, and irq is 0.
- R2: Data-out registers sit at runtime offsets 0x00, 0x04, 0x08 and 0x0A for ports 0 to 3. A write stores the byte and a read returns it. Writing one port leaves the other ports unchanged. Bits 7:5 of port 3 are not stored and read as 0.
- R3: Data-in registers sit at offsets 0x01, 0x05, 0x09 and 0x0B. Bit n reports the level of pad n of that port after two synchronizer flops. Bits 7:5 of port 3 read as 0. Writes to these offsets have no effect.
- R4: A write on the setup interface with cfg_addr=0 stores the pin select. Bits 6:4 hold the port and bits 2:0 hold the bit within the port. A read with cfg_addr=0 returns the stored value, with bits 7 and 3 read as 0.
- R5: With cfg_addr=1, the setup interface reads or writes the setup byte of the selected pin. Bit 0 is output enable, bit 1 is push-pull (0 means open-drain), bit 2 is pull-up, and bits 7:3 read 0. If the select names no existing pin (port 3 bits 5 to 7, or port 4 and above), the write is ignored and the read returns 0.
- R6: One cycle after the state changes, each pad's outputs follow its setup and data bit. In push-pull mode, pad_oe equals the output-enable bit and pad_out equals the data bit. In open-drain mode, pad_out is 0 and pad_oe is high only while the output-enable bit is 1 and the data bit is 0. pad_pu equals the pull-up bit.
- R7: Event-enable registers sit at 0x02 and 0x06 and event-status registers at 0x03 and 0x07, for ports 0 and 1 only. A status bit sets when its synchronized input rises while its enable bit is 1.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A rising edge in the same cycle as a clear leaves the bit set.
- R9: irq is a registered OR of all status bits whose enable bits are 1. Clearing an enable masks irq and keeps the status bit.
- R10: Offsets 0x0C to 0x0F read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_addr | input | 4 | Runtime register offset |
| rt_wr | input | 1 | Runtime write strobe |
| rt_wdata | input | 8 | Runtime write data |
| rt_rdata | output | 8 | Registered runtime read data |
| cfg_addr | input | 1 | 0 selects the pin-select byte, 1 selects the pin-setup byte |
| cfg_wr | input | 1 | Setup interface write strobe |
| cfg_wdata | input | 8 | Setup interface write data |
| cfg_rdata | output | 8 | Registered setup interface read data |
| pad_in | input | 29 | Asynchronous pad input levels |
| pad_out | output | 29 | Pad output data |
| pad_oe | output | 29 | Pad output enable |
| pad_pu | output | 29 | Pad pull-up request |
| irq | output | 1 | Event interrupt |

## Verification
Each pad output carries its setup and data state with one register of delay. A wrong setup bit, data bit or drive-style choice therefore shows on the pads on the clock after the faulty state arises, without any read.

Event status is only visible through irq and the status registers. A status bit that sets wrongly, or fails to clear, shows on irq one cycle later if its enable is 1. It shows on rt_rdata one cycle after its offset is addressed.

The reference model runs in lockstep with the design and compares every output on every cycle. A fault is therefore caught on the first cycle in which it reaches a port, including the synchronizer depth seen through the data-in registers.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BYTE_W = 8;
  // Bit positions inside the per-pin setup byte
  localparam int SETUP_OE   = 0;
  localparam int SETUP_PP   = 1;
  localparam int SETUP_PU   = 2;
  localparam int SETUP_W    = 3;
  // Pin-select field layout: port in [6:4], bit in [2:0]
  localparam logic [7:0] SEL_MASK = 8'h77;
  typedef logic [SETUP_W-1:0] setup_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 29,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] lvl_prev,
  input  logic         en_wr,
  input  logic         st_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] st_q
);
  logic [W-1:0] st_n;

  always_comb begin
    st_n = st_q;
    if (st_wr) st_n = st_n & ~wdata;
    // a new edge wins over a clear in the same cycle
    st_n = st_n | (lvl & ~lvl_prev & en_q & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata & mask;
      st_q <= st_n;
    end
  end
endmodule

// File: rtl/gpio_pincfg.sv
module gpio_pincfg
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_addr,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic [NPINS-1:0] oe,
  output logic [NPINS-1:0] pp,
  output logic [NPINS-1:0] pu
);
  logic [7:0] sel_q;
  logic [5:0] sel_idx;
  logic       sel_ok;
  setup_t     setup_q [NPINS];
  setup_t     sel_setup;

  assign sel_idx = {sel_q[6:4], sel_q[2:0]};
  assign sel_ok  = (32'(sel_idx) < NPINS);

  always_comb begin
    sel_setup = '0;
    for (int i = 0; i < NPINS; i++)
      if (sel_ok && (sel_idx == 6'(i))) sel_setup = setup_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      cfg_rdata <= '0;
      for (int i = 0; i < NPINS; i++) setup_q[i] <= '0;
    end else begin
      if (cfg_wr && !cfg_addr) sel_q <= cfg_wdata & SEL_MASK;
      if (cfg_wr && cfg_addr && sel_ok)
        for (int i = 0; i < NPINS; i++)
          if (sel_idx == 6'(i)) setup_q[i] <= cfg_wdata[SETUP_W-1:0];
      cfg_rdata <= cfg_addr ? {{(8-SETUP_W){1'b0}}, sel_setup} : sel_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_bits
    assign oe[i] = setup_q[i][SETUP_OE];
    assign pp[i] = setup_q[i][SETUP_PP];
    assign pu[i] = setup_q[i][SETUP_PU];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS     = 29,
  parameter int EV_PORTS  = 2,
  parameter int ADDR_W    = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_wr,
  input  logic [7:0]        rt_wdata,
  output logic [7:0]        rt_rdata,
  input  logic              cfg_addr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  output logic              irq
);
  localparam int NPORTS = (NPINS + BYTE_W - 1) / BYTE_W;
  localparam int VEC_W  = NPORTS * BYTE_W;
  localparam int EV_W   = EV_PORTS * BYTE_W;

  // Ports with events take four offsets, the rest take two
  function automatic int port_base(input int p);
    return (p < EV_PORTS) ? 4 * p : 4 * EV_PORTS + 2 * (p - EV_PORTS);
  endfunction

  logic [VEC_W-1:0]    pin_mask;
  logic [VEC_W-1:0]    dout_q;
  logic [NPINS-1:0]    in_s, in_prev;
  logic [VEC_W-1:0]    in_vec, prev_vec;
  logic [NPORTS-1:0]   wr_out;
  logic [EV_PORTS-1:0] en_wr, st_wr;
  logic [EV_W-1:0]     ev_en, ev_st;
  logic [NPINS-1:0]    cfg_oe, cfg_pp, cfg_pu;
  logic [7:0]          rd_next;

  for (genvar i = 0; i < VEC_W; i++) begin : g_mask
    assign pin_mask[i] = (i < NPINS) ? 1'b1 : 1'b0;
  end

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(in_s)
  );

  assign in_vec   = VEC_W'(in_s);
  assign prev_vec = VEC_W'(in_prev);

  for (genvar p = 0; p < NPORTS; p++) begin : g_wr
    assign wr_out[p] = rt_wr && (rt_addr == ADDR_W'(port_base(p)));
  end

  for (genvar e = 0; e < EV_PORTS; e++) begin : g_ev
    assign en_wr[e] = rt_wr && (rt_addr == ADDR_W'(port_base(e) + 2));
    assign st_wr[e] = rt_wr && (rt_addr == ADDR_W'(port_base(e) + 3));
    gpio_event #(.W(BYTE_W)) u_ev (
      .clk(clk), .rst(rst),
      .mask(pin_mask[e*BYTE_W +: BYTE_W]),
      .lvl(in_vec[e*BYTE_W +: BYTE_W]),
      .lvl_prev(prev_vec[e*BYTE_W +: BYTE_W]),
      .en_wr(en_wr[e]), .st_wr(st_wr[e]), .wdata(rt_wdata),
      .en_q(ev_en[e*BYTE_W +: BYTE_W]),
      .st_q(ev_st[e*BYTE_W +: BYTE_W])
    );
  end

  gpio_pincfg #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .oe(cfg_oe), .pp(cfg_pp), .pu(cfg_pu)
  );

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (rt_addr == ADDR_W'(port_base(p)))     rd_next = dout_q[p*BYTE_W +: BYTE_W];
      if (rt_addr == ADDR_W'(port_base(p) + 1)) rd_next = in_vec[p*BYTE_W +: BYTE_W];
    end
    for (int e = 0; e < EV_PORTS; e++) begin
      if (rt_addr == ADDR_W'(port_base(e) + 2)) rd_next = ev_en[e*BYTE_W +: BYTE_W];
      if (rt_addr == ADDR_W'(port_base(e) + 3)) rd_next = ev_st[e*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      in_prev  <= '0;
      rt_rdata <= '0;
      pad_out  <= '0;
      pad_oe   <= '0;
      pad_pu   <= '0;
      irq      <= 1'b0;
    end else begin
      for (int p = 0; p < NPORTS; p++)
        if (wr_out[p])
          dout_q[p*BYTE_W +: BYTE_W] <= rt_wdata & pin_mask[p*BYTE_W +: BYTE_W];
      in_prev  <= in_s;
      rt_rdata <= rd_next;
      pad_out  <= cfg_pp & dout_q[NPINS-1:0];
      pad_oe   <= cfg_oe & (cfg_pp | ~dout_q[NPINS-1:0]);
      pad_pu   <= cfg_pu;
      irq      <= |(ev_st & ev_en);
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS = 29,
  parameter int EV_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pp,
  input logic             irq,
  input logic [EV_W-1:0]  ev_en,
  input logic [EV_W-1:0]  ev_st,
  input logic             st_wr_any
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0 && !irq));

  // R6
  open_drain_never_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_out & ~$past(pp)) == '0);

  // R7
  status_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_st & ~$past(ev_st) & ~$past(ev_en)) == '0);

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !st_wr_any |=> ((~ev_st & $past(ev_st)) == '0));

  // R9
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
    ((ev_st & ev_en) == '0) |=> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .EV_W(EV_PORTS * 8)) u_chk (
  .clk(clk), .rst(rst), .pad_out(pad_out), .pad_oe(pad_oe), .pp(cfg_pp),
  .irq(irq), .ev_en(ev_en), .ev_st(ev_st), .st_wr_any(|st_wr)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rt_addr;
  logic        rt_wr;
  logic [7:0]  rt_wdata;
  logic [7:0]  rt_rdata;
  logic        cfg_addr;
  logic        cfg_wr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [28:0] pad_in;
  logic [28:0] pad_out, pad_oe, pad_pu;
  logic        irq;

  always #10 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst(rst), .rt_addr(rt_addr), .rt_wr(rt_wr), .rt_wdata(rt_wdata),
    .rt_rdata(rt_rdata), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    done   = 0;

  // Behavioural reference model
  logic [7:0]  m_out [4];
  logic [7:0]  m_en  [2];
  logic [7:0]  m_st  [2];
  logic [2:0]  m_cfg [29];
  logic [7:0]  m_sel;
  logic [28:0] m_s1, m_s2, m_prev;
  logic [7:0]  e_rt, e_cfg;
  logic [28:0] e_out, e_oe, e_pu;
  logic        e_irq;
  bit          seen_rst = 0;

  function automatic logic [7:0] rt_expect(input logic [3:0] a);
    logic [31:0] inx = {3'b000, m_s2};
    case (a)
      4'h0: return m_out[0];
      4'h1: return inx[7:0];
      4'h2: return m_en[0];
      4'h3: return m_st[0];
      4'h4: return m_out[1];
      4'h5: return inx[15:8];
      4'h6: return m_en[1];
      4'h7: return m_st[1];
      4'h8: return m_out[2];
      4'h9: return inx[23:16];
      4'hA: return m_out[3];
      4'hB: return inx[31:24];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    int pidx;
    logic [7:0] nst;
    logic [28:0] rise;
    bit irq_n;
    if (rst) begin
      seen_rst <= 1;
      for (int i = 0; i < 4; i++) m_out[i] <= 0;
      for (int i = 0; i < 2; i++) begin m_en[i] <= 0; m_st[i] <= 0; end
      for (int i = 0; i < 29; i++) m_cfg[i] <= 0;
      m_sel <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
      e_rt <= 0; e_cfg <= 0; e_out <= 0; e_oe <= 0; e_pu <= 0; e_irq <= 0;
    end else begin
      m_s1 <= pad_in; m_s2 <= m_s1; m_prev <= m_s2;
      rise = m_s2 & ~m_prev;
      e_rt <= rt_expect(rt_addr);
      pidx = int'(m_sel[6:4]) * 8 + int'(m_sel[2:0]);
      e_cfg <= cfg_addr ? ((pidx < 29) ? {5'b0, m_cfg[pidx]} : 8'h00) : m_sel;
      if (cfg_wr && !cfg_addr) m_sel <= cfg_wdata & 8'h77;
      if (cfg_wr && cfg_addr && pidx < 29) m_cfg[pidx] <= cfg_wdata[2:0];
      if (rt_wr) begin
        case (rt_addr)
          4'h0: m_out[0] <= rt_wdata;
          4'h4: m_out[1] <= rt_wdata;
          4'h8: m_out[2] <= rt_wdata;
          4'hA: m_out[3] <= rt_wdata & 8'h1F;
          4'h2: m_en[0]  <= rt_wdata;
          4'h6: m_en[1]  <= rt_wdata;
          default: ;
        endcase
      end
      irq_n = 0;
      for (int e = 0; e < 2; e++) begin
        nst = m_st[e];
        if (rt_wr && rt_addr == 4'(3 + 4 * e)) nst = nst & ~rt_wdata;
        nst = nst | (rise[e*8 +: 8] & m_en[e]);
        m_st[e] <= nst;
        if ((m_st[e] & m_en[e]) != 0) irq_n = 1;
      end
      e_irq <= irq_n;
      for (int i = 0; i < 29; i++) begin
        logic d;
        d = m_out[i / 8][i % 8];
        e_out[i] <= m_cfg[i][1] & d;
        e_oe[i]  <= m_cfg[i][0] & (m_cfg[i][1] | ~d);
        e_pu[i]  <= m_cfg[i][2];
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seen_rst && !done) begin
      chk("rt_rdata",  32'(rt_rdata),  32'(e_rt));
      chk("cfg_rdata", 32'(cfg_rdata), 32'(e_cfg));
      chk("pad_out",   32'(pad_out),   32'(e_out));
      chk("pad_oe",    32'(pad_oe),    32'(e_oe));
      chk("pad_pu",    32'(pad_pu),    32'(e_pu));
      chk("irq",       32'(irq),       32'(e_irq));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rt_write(input logic [3:0] a, input logic [7:0] d);
    rt_addr = a; rt_wdata = d; rt_wr = 1;
    @(negedge clk);
    rt_wr = 0;
  endtask

  task automatic rt_look(input logic [3:0] a);
    rt_addr = a;
    idle(2);
  endtask

  task automatic cfg_write(input logic a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_look(input logic a);
    cfg_addr = a;
    idle(2);
  endtask

  task automatic set_pin(input logic [7:0] sel, input logic [7:0] setup);
    cfg_write(0, sel);
    cfg_write(1, setup);
    cfg_look(1);
  endtask

  initial begin
    rst = 1; rt_addr = 0; rt_wr = 0; rt_wdata = 0;
    cfg_addr = 0; cfg_wr = 0; cfg_wdata = 0; pad_in = 0;
    idle(3);
    rst = 0;
    // R1: reset state seen on every offset and both setup reads
    phase = "R1";
    for (int a = 0; a < 16; a++) rt_look(4'(a));
    cfg_look(0); cfg_look(1);

    // R2: data-out storage and port isolation
    phase = "R2";
    rt_write(4'h0, 8'hA5); rt_write(4'h4, 8'h3C); rt_write(4'h8, 8'hF0);
    rt_write(4'hA, 8'hFF);
    rt_look(4'h0); rt_look(4'h4); rt_look(4'h8); rt_look(4'hA);
    rt_write(4'h4, 8'h81);
    rt_look(4'h0); rt_look(4'h4); rt_look(4'h8);

    // R3: data-in after the synchronizer, write ignored
    phase = "R3";
    rt_addr = 4'h1;
    pad_in = 29'h1ABC_DE5A;
    idle(4);
    rt_write(4'h1, 8'h00); rt_write(4'hB, 8'hFF);
    rt_look(4'h1); rt_look(4'h5); rt_look(4'h9); rt_look(4'hB);
    pad_in = 29'h0F0F_0F0F; rt_addr = 4'hB; idle(4);

    // R4: pin select fields
    phase = "R4";
    cfg_write(0, 8'hFF); cfg_look(0);
    cfg_write(0, 8'h25); cfg_look(0);

    // R5: setup bytes, invalid selects
    phase = "R5";
    set_pin(8'h00, 8'hFF);
    set_pin(8'h34, 8'h05);
    set_pin(8'h35, 8'h07);
    set_pin(8'h40, 8'h07);
    set_pin(8'h17, 8'h02);
    cfg_write(0, 8'h00); cfg_look(1);

    // R6: drive styles against data bits
    phase = "R6";
    rt_write(4'h0, 8'h0F);
    set_pin(8'h01, 8'h03);
    set_pin(8'h02, 8'h01);
    set_pin(8'h06, 8'h01);
    set_pin(8'h07, 8'h07);
    rt_write(4'h0, 8'hC4); idle(2);
    set_pin(8'h34, 8'h03);
    rt_write(4'hA, 8'h10); idle(2);
    rt_write(4'hA, 8'h00); idle(2);

    // R7: event detection on ports 0 and 1
    phase = "R7";
    pad_in = 0; idle(4);
    rt_write(4'h2, 8'h0F); rt_write(4'h6, 8'h80);
    pad_in = 29'h0000_80FF; idle(4);
    rt_look(4'h3); rt_look(4'h7);
    pad_in = 0; idle(4);
    rt_look(4'h3);

    // R8: write-one-to-clear, write zero keeps, clash with edge
    phase = "R8";
    rt_write(4'h3, 8'h00); rt_look(4'h3);
    rt_write(4'h3, 8'h05); rt_look(4'h3);
    for (int k = 0; k < 6; k++) begin
      pad_in[0] = ~pad_in[0];
      rt_write(4'h3, 8'hFF);
    end
    rt_look(4'h3); rt_write(4'h7, 8'hFF); rt_look(4'h7);

    // R9: irq masking by enable
    phase = "R9";
    rt_write(4'h3, 8'hFF); idle(2);
    pad_in[1] = 1; idle(4);
    rt_write(4'h2, 8'h00); idle(2);
    rt_look(4'h3);
    rt_write(4'h2, 8'h02); idle(2);
    rt_write(4'h3, 8'h02); idle(2);

    // R10: undefined offsets
    phase = "R10";
    for (int a = 12; a < 16; a++) rt_write(4'(a), 8'hFF);
    for (int a = 0; a < 16; a++) rt_look(4'(a));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog %s actual=running expected=finished", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule